// File: doc/BRIEF.md
# Flash Write-Status Bit Generator

This block produces the word a NOR-style flash device returns on a read while one of its embedded operations is in progress. Decoded command events arrive from an upstream command decoder: start program, sector erase, chip erase, suspend, resume, buffered-write load, buffered-write abort and abort-reset. Two events come from the operation engine: done and time limit exceeded. From these the block tracks the device mode. A read strobe and a flag that says whether the read address falls in the sector under operation (or under suspension) select what the read returns. The result is either the array data passed through, or a status word built from a polling bit, two toggle bits, a time-limit flag, an erase-start flag and a buffered-write abort flag. A ready/busy level is produced alongside.

A sector erase first opens an accumulation window, `WINDOW_CYC` clock cycles long, during which further sector erase commands are accepted and each one restarts the window. When the window expires the erase is taken as started. After that, only suspend is honoured until the operation ends. Both toggle bits advance only on a rising edge of the read strobe. Both clear whenever the block is back in array-read mode.

Top module: `flash_status_gen`

## Requirements
- R1: A synchronous active-high reset puts the block in array-read mode. In that mode `status` follows `array_data` in the same cycle and `ready` is 1. The status bit positions are DQ7=bit 7, DQ6=bit 6, DQ5=bit 5, DQ3=bit 3, DQ2=bit 2 and DQ1=bit 1. Bits 4 and 0, and any bit not defined in the current mode, read 0.
- R2: A sector erase from array mode makes `ready` 0 and bit 7 read 0. Bit 3 reads 0 for `WINDOW_CYC` clock edges counted from the edge that takes the command, and reads 1 from the next edge on.
- R3: Each further sector erase taken while the window is open restarts the full window of `WINDOW_CYC` edges.
- R4: A chip erase skips the window: bit 3 reads 1 from the edge that takes the command.
- R5: While an erase runs with bit 3 at 1, program, sector erase, chip erase, buffered-write load and resume commands are ignored. Suspend is honoured.
- R6: During a program, a buffered-write busy or abort state, and a program issued inside an erase suspend, bit 7 reads the complement of `prog_bit7`.
- R7: Bit 6 inverts on each rising edge of `rd_strobe` while a program, erase, suspended-erase program or buffered write is active. In an erase-suspend read of the suspended sector it reads 0.
- R8: Bit 2 inverts on each rising edge of `rd_strobe` during an erase, and during an erase-suspend read of the suspended sector. It reads 0 during a program.
- R9: In an erase suspend, `ready` is 1. A read of the suspended sector returns bit 7=1, bit 3=0 and the bit-2 toggle; other sectors return `array_data`. In a program suspend, `ready` is 1, the suspended sector reads 0x00 and other sectors return `array_data`.
- R10: `op_timeout` during a busy operation sets bit 5. Bit 5 stays set, and `op_done` is ignored, until `cmd_abort_reset` returns the block to array mode.
- R11: A buffered-write abort sets bit 1 and keeps `ready` at 0 until `cmd_abort_reset`. The abort-reset returns the block to array mode.
- R12: A resume from erase suspend returns to the erase with bit 3 at 1 and `ready` at 0. A done during a suspended-erase program returns to the erase-suspend read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_program | input | 1 | Start program event |
| cmd_sector_erase | input | 1 | Sector erase (initial or added) event |
| cmd_chip_erase | input | 1 | Chip erase event |
| cmd_suspend | input | 1 | Suspend the running program or erase |
| cmd_resume | input | 1 | Resume the suspended operation |
| cmd_wbuf_load | input | 1 | Start buffered-write event |
| cmd_wbuf_abort | input | 1 | Buffered write aborted |
| cmd_abort_reset | input | 1 | Clear abort or time-limit fault, back to array mode |
| op_done | input | 1 | Embedded operation finished |
| op_timeout | input | 1 | Embedded operation exceeded its time limit |
| rd_strobe | input | 1 | Read strobe; rising edge advances toggle bits |
| rd_in_op_sector | input | 1 | Read address is in the active or suspended sector |
| prog_bit7 | input | 1 | Bit 7 of the data being written |
| array_data | input | 8 | Array data for passthrough reads |
| status | output | 8 | Read word: status bits or array data |
| ready | output | 1 | 1 = ready, 0 = busy |

## Verification
Mode changes and window loads register on the clock edge that takes a command, so `status` and `ready` are due one edge after a command is driven. The toggle bits advance on the first edge that sees `rd_strobe` high, so they are due one edge after the strobe rises. The window output is due exactly `WINDOW_CYC` edges after the edge that took the last sector erase. The bench drives every input on the falling clock edge, counts the rising edges named above, and samples on the following falling edge. It also keeps its own model of both toggle bits, advanced once per read in the modes where each requirement says it moves.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

    typedef enum logic [2:0] {
        M_ARRAY,
        M_PROG,
        M_ERASE,
        M_ESUS,
        M_ESPROG,
        M_PSUS,
        M_WBUF,
        M_WABORT
    } fsg_mode_e;

    typedef struct packed {
        fsg_mode_e mode;
        logic      fault;
    } ctrl_state_t;

    typedef struct packed {
        logic rd;
        logic t6;
        logic t2;
    } tog_state_t;

    localparam int STATUS_W = 8;

endpackage

// File: rtl/fsg_mode_ctrl.sv
module fsg_mode_ctrl
    import fsg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cmd_program,
    input  logic      cmd_sector_erase,
    input  logic      cmd_chip_erase,
    input  logic      cmd_suspend,
    input  logic      cmd_resume,
    input  logic      cmd_wbuf_load,
    input  logic      cmd_wbuf_abort,
    input  logic      cmd_abort_reset,
    input  logic      op_done,
    input  logic      op_timeout,
    input  logic      win_open,
    output fsg_mode_e mode_o,
    output logic      fault_o,
    output logic      win_load_o
);

    ctrl_state_t st_d, st_q;
    logic        busy;

    always_comb begin
        st_d       = st_q;
        win_load_o = 1'b0;
        busy = (st_q.mode == M_PROG) || (st_q.mode == M_ERASE) ||
               (st_q.mode == M_ESPROG) || (st_q.mode == M_WBUF);
        unique case (st_q.mode)
            M_ARRAY: begin
                if (cmd_program) begin
                    st_d.mode = M_PROG;
                end else if (cmd_sector_erase) begin
                    st_d.mode  = M_ERASE;
                    win_load_o = 1'b1;
                end else if (cmd_chip_erase) begin
                    st_d.mode = M_ERASE;
                end else if (cmd_wbuf_load) begin
                    st_d.mode = M_WBUF;
                end
            end
            M_PROG: begin
                if (!st_q.fault) begin
                    if (cmd_suspend)  st_d.mode = M_PSUS;
                    else if (op_done) st_d.mode = M_ARRAY;
                end
            end
            M_PSUS: begin
                if (cmd_resume) st_d.mode = M_PROG;
            end
            M_ERASE: begin
                if (!st_q.fault) begin
                    if (win_open) begin
                        if (cmd_sector_erase) win_load_o = 1'b1;
                    end else if (cmd_suspend) begin
                        st_d.mode = M_ESUS;
                    end else if (op_done) begin
                        st_d.mode = M_ARRAY;
                    end
                end
            end
            M_ESUS: begin
                if (cmd_program)     st_d.mode = M_ESPROG;
                else if (cmd_resume) st_d.mode = M_ERASE;
            end
            M_ESPROG: begin
                if (!st_q.fault && op_done) st_d.mode = M_ESUS;
            end
            M_WBUF: begin
                if (!st_q.fault) begin
                    if (cmd_wbuf_abort) st_d.mode = M_WABORT;
                    else if (op_done)   st_d.mode = M_ARRAY;
                end
            end
            M_WABORT: begin
                if (cmd_abort_reset) st_d.mode = M_ARRAY;
            end
            default: st_d.mode = M_ARRAY;
        endcase
        if (busy && op_timeout && !st_q.fault) begin
            st_d.fault = 1'b1;
        end
        if (st_q.fault && cmd_abort_reset) begin
            st_d.mode  = M_ARRAY;
            st_d.fault = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.mode  <= M_ARRAY;
            st_q.fault <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o  = st_q.mode;
    assign fault_o = st_q.fault;

    // R5: a started erase holds against everything but suspend, done and fault handling
    p_erase_locked_r5: assert property (@(posedge clk) disable iff (rst)
        (st_q.mode == M_ERASE && !win_open && !cmd_suspend && !op_done &&
         !cmd_abort_reset) |=> (st_q.mode == M_ERASE));

    // R10: the time-limit flag is sticky until abort-reset
    p_fault_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (st_q.fault && !cmd_abort_reset) |=> st_q.fault);

    // R11: the buffered-write abort state is left only through abort-reset
    p_abort_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (st_q.mode == M_WABORT && !cmd_abort_reset) |=> (st_q.mode == M_WABORT));

endmodule

// File: rtl/fsg_erase_window.sv
module fsg_erase_window #(
    parameter int WINDOW_CYC = 2500
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    input  logic clr_i,
    output logic open_o
);

    localparam int CNT_W = $clog2(WINDOW_CYC + 1);

    typedef struct packed {
        logic             open;
        logic [CNT_W-1:0] cnt;
    } win_state_t;

    win_state_t w_d, w_q;

    always_comb begin
        w_d = w_q;
        if (load_i) begin
            w_d.open = 1'b1;
            w_d.cnt  = CNT_W'(WINDOW_CYC);
        end else if (clr_i) begin
            w_d.open = 1'b0;
            w_d.cnt  = '0;
        end else if (w_q.open) begin
            if (w_q.cnt == CNT_W'(1)) w_d.open = 1'b0;
            w_d.cnt = w_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            w_q.open <= 1'b0;
            w_q.cnt  <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    assign open_o = w_q.open;

    // R3: every taken sector erase leaves the window open on the next cycle
    p_load_opens_r3: assert property (@(posedge clk) disable iff (rst)
        load_i |=> open_o);

    // R2: the window can only close from an open state, never reopen without a load
    p_no_spurious_open_r2: assert property (@(posedge clk) disable iff (rst)
        (!open_o && !load_i) |=> !open_o);

endmodule

// File: rtl/fsg_toggle_pair.sv
module fsg_toggle_pair
    import fsg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rd_strobe,
    input  logic en6_i,
    input  logic en2_i,
    input  logic clr_i,
    output logic t6_o,
    output logic t2_o
);

    tog_state_t g_d, g_q;
    logic       rise;

    always_comb begin
        rise   = rd_strobe && !g_q.rd;
        g_d    = g_q;
        g_d.rd = rd_strobe;
        if (clr_i) begin
            g_d.t6 = 1'b0;
            g_d.t2 = 1'b0;
        end else begin
            if (rise && en6_i) g_d.t6 = !g_q.t6;
            if (rise && en2_i) g_d.t2 = !g_q.t2;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign t6_o = g_q.t6;
    assign t2_o = g_q.t2;

    // R7: an enabled read edge flips the DQ6 toggle
    p_dq6_flip_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && !g_q.rd && en6_i && !clr_i) |=> (t6_o != $past(t6_o)));

    // R8: without a read edge the DQ2 toggle holds
    p_dq2_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!(rd_strobe && !g_q.rd) && !clr_i) |=> $stable(t2_o));

endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
    import fsg_pkg::*;
#(
    parameter int WINDOW_CYC = 2500
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_program,
    input  logic       cmd_sector_erase,
    input  logic       cmd_chip_erase,
    input  logic       cmd_suspend,
    input  logic       cmd_resume,
    input  logic       cmd_wbuf_load,
    input  logic       cmd_wbuf_abort,
    input  logic       cmd_abort_reset,
    input  logic       op_done,
    input  logic       op_timeout,
    input  logic       rd_strobe,
    input  logic       rd_in_op_sector,
    input  logic       prog_bit7,
    input  logic [7:0] array_data,
    output logic [7:0] status,
    output logic       ready
);

    fsg_mode_e mode;
    logic      fault, win_open, win_load;
    logic      t6, t2, en6, en2;

    fsg_mode_ctrl u_ctrl (
        .clk             (clk),
        .rst             (rst),
        .cmd_program     (cmd_program),
        .cmd_sector_erase(cmd_sector_erase),
        .cmd_chip_erase  (cmd_chip_erase),
        .cmd_suspend     (cmd_suspend),
        .cmd_resume      (cmd_resume),
        .cmd_wbuf_load   (cmd_wbuf_load),
        .cmd_wbuf_abort  (cmd_wbuf_abort),
        .cmd_abort_reset (cmd_abort_reset),
        .op_done         (op_done),
        .op_timeout      (op_timeout),
        .win_open        (win_open),
        .mode_o          (mode),
        .fault_o         (fault),
        .win_load_o      (win_load)
    );

    fsg_erase_window #(.WINDOW_CYC(WINDOW_CYC)) u_win (
        .clk   (clk),
        .rst   (rst),
        .load_i(win_load),
        .clr_i (mode != M_ERASE),
        .open_o(win_open)
    );

    assign en6 = (mode == M_PROG) || (mode == M_ERASE) || (mode == M_ESPROG) ||
                 (mode == M_WBUF) || (mode == M_WABORT);
    assign en2 = (mode == M_ERASE) || ((mode == M_ESUS) && rd_in_op_sector);

    fsg_toggle_pair u_tog (
        .clk      (clk),
        .rst      (rst),
        .rd_strobe(rd_strobe),
        .en6_i    (en6),
        .en2_i    (en2),
        .clr_i    (mode == M_ARRAY),
        .t6_o     (t6),
        .t2_o     (t2)
    );

    always_comb begin
        status = '0;
        ready  = 1'b0;
        unique case (mode)
            M_ARRAY: begin
                status = array_data;
                ready  = 1'b1;
            end
            M_PROG, M_ESPROG, M_WBUF: begin
                status[7] = !prog_bit7;
                status[6] = t6;
                status[5] = fault;
            end
            M_WABORT: begin
                status[7] = !prog_bit7;
                status[6] = t6;
                status[5] = fault;
                status[1] = 1'b1;
            end
            M_ERASE: begin
                status[6] = t6;
                status[5] = fault;
                status[3] = !win_open;
                status[2] = t2;
            end
            M_ESUS: begin
                ready = 1'b1;
                if (rd_in_op_sector) begin
                    status[7] = 1'b1;
                    status[2] = t2;
                end else begin
                    status = array_data;
                end
            end
            M_PSUS: begin
                ready = 1'b1;
                if (!rd_in_op_sector) status = array_data;
            end
            default: begin
                status = '0;
                ready  = 1'b0;
            end
        endcase
    end

    // R1: the cycle after reset the block is ready and passes array data
    p_reset_ready_r1: assert property (@(posedge clk)
        $past(rst) |-> (ready && status == array_data));

    // R2: a sector erase taken from array mode leaves the erase-start flag low
    p_window_starts_low_r2: assert property (@(posedge clk) disable iff (rst)
        (mode == M_ARRAY && !cmd_program && cmd_sector_erase) |=> (!status[3] && !ready));

endmodule

// File: tb/flash_status_gen_bench.sv
module flash_status_gen_bench;

    localparam int W = 16;

    logic       clk = 1'b0;
    logic       rst;
    logic       cmd_program, cmd_sector_erase, cmd_chip_erase, cmd_suspend, cmd_resume;
    logic       cmd_wbuf_load, cmd_wbuf_abort, cmd_abort_reset, op_done, op_timeout;
    logic       rd_strobe, rd_in_op_sector, prog_bit7;
    logic [7:0] array_data, status;
    logic       ready;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;
    bit m6, m2;

    always #10 clk = ~clk;

    flash_status_gen #(.WINDOW_CYC(W)) u_flash_status_gen (
        .clk(clk), .rst(rst),
        .cmd_program(cmd_program), .cmd_sector_erase(cmd_sector_erase),
        .cmd_chip_erase(cmd_chip_erase), .cmd_suspend(cmd_suspend),
        .cmd_resume(cmd_resume), .cmd_wbuf_load(cmd_wbuf_load),
        .cmd_wbuf_abort(cmd_wbuf_abort), .cmd_abort_reset(cmd_abort_reset),
        .op_done(op_done), .op_timeout(op_timeout),
        .rd_strobe(rd_strobe), .rd_in_op_sector(rd_in_op_sector),
        .prog_bit7(prog_bit7), .array_data(array_data),
        .status(status), .ready(ready)
    );

    localparam int C_PROG = 0, C_SECT = 1, C_CHIP = 2, C_SUSP = 3, C_RES = 4;
    localparam int C_WBUF = 5, C_WABT = 6, C_ARST = 7, C_DONE = 8, C_TOUT = 9;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int c);
        @(negedge clk);
        case (c)
            C_PROG: cmd_program      = 1'b1;
            C_SECT: cmd_sector_erase = 1'b1;
            C_CHIP: cmd_chip_erase   = 1'b1;
            C_SUSP: cmd_suspend      = 1'b1;
            C_RES:  cmd_resume       = 1'b1;
            C_WBUF: cmd_wbuf_load    = 1'b1;
            C_WABT: cmd_wbuf_abort   = 1'b1;
            C_ARST: cmd_abort_reset  = 1'b1;
            C_DONE: op_done          = 1'b1;
            default: op_timeout      = 1'b1;
        endcase
        @(negedge clk);
        {cmd_program, cmd_sector_erase, cmd_chip_erase, cmd_suspend, cmd_resume} = '0;
        {cmd_wbuf_load, cmd_wbuf_abort, cmd_abort_reset, op_done, op_timeout} = '0;
    endtask

    task automatic do_read(input bit f6, input bit f2);
        @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        m6 = m6 ^ f6;
        m2 = m2 ^ f2;
    endtask

    function automatic logic [7:0] erase_word(input bit d3);
        return {1'b0, m6, 1'b0, 1'b0, d3, m2, 2'b00};
    endfunction

    task automatic t_reset();
        array_data = 8'h5A;
        tick(1);
        chk("R1 reset passthrough", status, 8'h5A);
        chk("R1 reset ready", {7'b0, ready}, 8'h01);
        array_data = 8'hC3;
        tick(1);
        chk("R1 passthrough follows", status, 8'hC3);
    endtask

    task automatic t_sector_erase();
        m6 = 0; m2 = 0;
        pulse(C_SECT);
        chk("R2 busy after sector erase", {7'b0, ready}, 8'h00);
        chk("R2 window open word", status, erase_word(1'b0));
        tick(W - 1);
        chk("R2 dq3 low at last window edge", {7'b0, status[3]}, 8'h00);
        tick(1);
        chk("R2 dq3 high after window", status, erase_word(1'b1));
        pulse(C_PROG); pulse(C_WBUF); pulse(C_CHIP); pulse(C_SECT); pulse(C_RES);
        chk("R5 commands ignored", status, erase_word(1'b1));
        chk("R5 still busy", {7'b0, ready}, 8'h00);
        do_read(1'b1, 1'b1);
        chk("R7 R8 erase toggles first read", status, erase_word(1'b1));
        do_read(1'b1, 1'b1);
        chk("R7 R8 erase toggles second read", status, erase_word(1'b1));
        do_read(1'b1, 1'b1);
        chk("R8 erase dq2 third read", status, erase_word(1'b1));
        pulse(C_SUSP);
        rd_in_op_sector = 1'b1;
        tick(1);
        chk("R9 erase suspend ready", {7'b0, ready}, 8'h01);
        chk("R9 suspended sector word", status, {1'b1, 4'b0, m2, 2'b0});
        do_read(1'b0, 1'b1);
        chk("R7 R8 suspend read dq2 only", status, {1'b1, 4'b0, m2, 2'b0});
        rd_in_op_sector = 1'b0;
        array_data = 8'h3C;
        tick(1);
        chk("R9 other sector array data", status, 8'h3C);
        prog_bit7 = 1'b1;
        pulse(C_PROG);
        chk("R6 suspended-erase program dq7", status, {1'b0, m6, 6'b0});
        chk("R6 suspended-erase program busy", {7'b0, ready}, 8'h00);
        do_read(1'b1, 1'b0);
        chk("R7 suspended-erase program dq6", status, {1'b0, m6, 6'b0});
        pulse(C_DONE);
        rd_in_op_sector = 1'b1;
        tick(1);
        chk("R12 back to erase suspend", status, {1'b1, 4'b0, m2, 2'b0});
        pulse(C_RES);
        chk("R12 resume erase dq3", status, erase_word(1'b1));
        chk("R12 resume busy", {7'b0, ready}, 8'h00);
        rd_in_op_sector = 1'b0;
        pulse(C_DONE);
        chk("R1 erase done array read", status, 8'h3C);
    endtask

    task automatic t_restart();
        m6 = 0; m2 = 0;
        pulse(C_SECT);
        tick(10);
        pulse(C_SECT);
        tick(W - 1);
        chk("R3 window restarted still low", {7'b0, status[3]}, 8'h00);
        tick(1);
        chk("R3 window ends after restart", {7'b0, status[3]}, 8'h01);
        pulse(C_DONE);
        chk("R3 done returns ready", {7'b0, ready}, 8'h01);
    endtask

    task automatic t_chip();
        m6 = 0; m2 = 0;
        pulse(C_CHIP);
        chk("R4 chip erase dq3 at once", status, erase_word(1'b1));
        chk("R4 chip erase busy", {7'b0, ready}, 8'h00);
        pulse(C_DONE);
    endtask

    task automatic t_program();
        m6 = 0; m2 = 0;
        prog_bit7 = 1'b0;
        pulse(C_PROG);
        chk("R6 program dq7 complement", status, 8'h80);
        do_read(1'b1, 1'b0);
        chk("R7 R8 program dq6 toggles dq2 zero", status, {1'b1, m6, 6'b0});
        do_read(1'b1, 1'b0);
        chk("R7 program dq6 second read", status, {1'b1, m6, 6'b0});
        pulse(C_SUSP);
        rd_in_op_sector = 1'b1;
        tick(1);
        chk("R9 program suspend sector", status, 8'h00);
        chk("R9 program suspend ready", {7'b0, ready}, 8'h01);
        rd_in_op_sector = 1'b0;
        array_data = 8'hA5;
        tick(1);
        chk("R9 program suspend other sector", status, 8'hA5);
        pulse(C_RES);
        chk("R12 program resumed busy", {7'b0, ready}, 8'h00);
        pulse(C_DONE);
        chk("R1 program done passthrough", status, 8'hA5);
    endtask

    task automatic t_timeout();
        m6 = 0; m2 = 0;
        prog_bit7 = 1'b1;
        pulse(C_PROG);
        pulse(C_TOUT);
        chk("R10 dq5 set", status, 8'h20);
        pulse(C_DONE);
        chk("R10 done ignored under fault", status, 8'h20);
        chk("R10 busy under fault", {7'b0, ready}, 8'h00);
        pulse(C_ARST);
        chk("R10 abort-reset clears", status, 8'hA5);
        chk("R10 ready after clear", {7'b0, ready}, 8'h01);
    endtask

    task automatic t_wbuf();
        m6 = 0; m2 = 0;
        prog_bit7 = 1'b0;
        pulse(C_WBUF);
        chk("R6 buffer busy word", status, 8'h80);
        pulse(C_WABT);
        chk("R11 abort sets dq1", status, 8'h82);
        pulse(C_DONE);
        do_read(1'b1, 1'b0);
        chk("R11 abort holds and dq6 toggles", status, {1'b1, m6, 4'b0, 1'b1, 1'b0});
        chk("R11 abort busy", {7'b0, ready}, 8'h00);
        pulse(C_ARST);
        chk("R11 abort-reset to array", status, 8'hA5);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        rst = 1'b1;
        {cmd_program, cmd_sector_erase, cmd_chip_erase, cmd_suspend, cmd_resume} = '0;
        {cmd_wbuf_load, cmd_wbuf_abort, cmd_abort_reset, op_done, op_timeout} = '0;
        rd_strobe = 1'b0;
        rd_in_op_sector = 1'b0;
        prog_bit7 = 1'b0;
        array_data = 8'h00;
        tick(3);
        rst = 1'b0;
        t_reset();
        t_sector_erase();
        t_restart();
        t_chip();
        t_program();
        t_timeout();
        t_wbuf();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

endmodule